// File: doc/BRIEF.md
# Class-level round-robin command arbiter

This block decides which traffic class may put the next DRAM command on the bus in a memory controller that keeps one request queue per cache-partition class. Each class offers at most one command candidate per cycle. The candidate has a valid flag and a kind flag that says whether it is row-level (activate or precharge) or column-level (read or write). The candidates arrive already qualified: each class has applied its own ordering, where a request that can issue a read or write at once beats non-ready ones and the oldest request wins a tie. DRAM timing and bank state have also been checked. Fairness between classes is the top ordering tier, so it is decided here, above that per-class ordering.

Classes are served in round-robin order, and a class with nothing to issue is skipped. A class that wins the grant and issues a row-level command keeps the grant until it issues a column-level command. This stops two classes from taking turns opening and closing rows in a bank they share. While the holding class has no candidate, the grant stays with it and no other class issues. The grant and the issue strobe are decided in the same cycle as the candidates.

Top module: `clsarb_top`

## Requirements
- R1: At most one bit of `grant_oh` is set in any cycle, and `cmd_issue` is 1 exactly when the granted class has `cand_valid` set.
- R2: When no class holds the grant, the grant goes to the first class with `cand_valid`=1, searching from the round-robin pointer upward and wrapping past NUM_CLS-1 to 0. Classes with `cand_valid`=0 are skipped.
- R3: When the granted class issues a row-level command (`cand_col`=0), the same class holds the grant in the next cycle, whatever the other classes request.
- R4: When the granted class issues a column-level command (`cand_col`=1), it gives up the grant, and the pointer moves to that class index plus one, modulo NUM_CLS.
- R5: While a class holds the grant and has `cand_valid`=0, `grant_oh` keeps pointing at it and `cmd_issue` is 0, even if other classes are valid.
- R6: After a synchronous active-low reset, no class holds the grant and the pointer is 0. The first grant therefore goes to the lowest-indexed valid class.
- R7: When no class holds the grant and no candidate is valid, `grant_oh` is all zeros and `cmd_issue` is 0.
- R8: When every class has a candidate valid in every cycle, the numbers of column-level commands issued per class differ by at most one over any run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | NUM_CLS | Per class: a qualified command candidate is present |
| cand_col | input | NUM_CLS | Per class: candidate is column-level (1) or row-level (0) |
| grant_oh | output | NUM_CLS | One-hot class that may issue this cycle; zero when idle |
| cmd_issue | output | 1 | The granted class issues its candidate this cycle |

## Verification
A held flag that is wrongly cleared shows up in the same cycle. `grant_oh` moves to another valid class in the cycle after a row-level issue, or during a stall where the holding class has no candidate. A pointer that advances wrongly does not show until the next free arbitration, which is the first cycle after a column-level release. It then shows as a grant to the wrong class whenever two or more classes are valid. Over a long run of continuous demand, a skewed pointer also shows as column counts that drift apart by more than one.

// File: rtl/clsarb_pkg.sv
// Package: shared limits and command-kind encoding for the class arbiter.
// Assumes: the number of classes stays within MAX_CLS.
package clsarb_pkg;
    localparam int MIN_CLS = 2;
    localparam int MAX_CLS = 16;

    typedef enum logic {
        KIND_ROW = 1'b0,
        KIND_COL = 1'b1
    } cmd_kind_e;
endpackage

// File: rtl/clsarb_rr_pick.sv
// Module: rotating priority picker. It returns the first set request at or
// above the pointer, wrapping to index 0 if none is found there.
// Assumes: ptr < N.
module clsarb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] win_idx,
    output logic          win_any
);
    logic [N-1:0] upper_mask;
    logic [N-1:0] upper_req;
    logic [N-1:0] search_vec;

    // Mask of the class positions at or above the pointer.
    generate
        for (genvar g = 0; g < N; g++) begin : g_mask
            assign upper_mask[g] = (IW'(g) >= ptr);
        end
    endgenerate

    assign upper_req  = req & upper_mask;
    assign search_vec = (|upper_req) ? upper_req : req;
    assign win_any    = |req;

    // Lowest set position of the chosen search vector.
    always_comb begin
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (search_vec[i]) win_idx = IW'(i);
        end
    end
endmodule

// File: rtl/clsarb_hold.sv
// Module: grant-hold state and round-robin pointer. Holds the issuing class
// after a row-level issue, and after a column-level issue releases it and
// moves the pointer to the next class.
// Assumes: cur_idx < N whenever issue is high.
module clsarb_hold #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          issue_col,
    input  logic [IW-1:0] cur_idx,
    output logic          hold_vld,
    output logic [IW-1:0] hold_idx,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    // Update the hold flag, the holder index and the pointer on each issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_idx <= '0;
            ptr      <= '0;
        end else if (issue) begin
            if (issue_col) begin
                hold_vld <= 1'b0;
                ptr      <= (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
            end else begin
                hold_vld <= 1'b1;
                hold_idx <= cur_idx;
            end
        end
    end

    AST_COL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        issue && issue_col |=> !hold_vld);  // R4
    AST_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        issue && issue_col |=> ptr == (($past(cur_idx) == LAST_IDX) ? '0 : $past(cur_idx) + 1'b1));  // R4
    AST_ROW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !issue_col |=> hold_vld && hold_idx == $past(cur_idx));  // R3
endmodule

// File: rtl/clsarb_dec.sv
// Module: index to one-hot decoder with an enable.
// Assumes: idx < N whenever en is high.
module clsarb_dec #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  oh
);
    // One output line per class.
    generate
        for (genvar g = 0; g < N; g++) begin : g_dec
            assign oh[g] = en && (idx == IW'(g));
        end
    endgenerate
endmodule

// File: rtl/clsarb_top.sv
// Module: class-level round-robin DRAM command arbiter. Picks one class per
// cycle and keeps the grant with a class across row-level commands until
// it issues a column-level command.
// Assumes: candidates arrive pre-qualified for DRAM timing and bank state.
module clsarb_top
    import clsarb_pkg::*;
#(
    parameter int NUM_CLS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLS-1:0] cand_valid,
    input  logic [NUM_CLS-1:0] cand_col,
    output logic [NUM_CLS-1:0] grant_oh,
    output logic               cmd_issue
);
    localparam int IW = $clog2(NUM_CLS);

    logic          hold_vld;
    logic [IW-1:0] hold_idx;
    logic [IW-1:0] rr_ptr;
    logic [IW-1:0] pick_idx;
    logic          pick_any;
    logic [IW-1:0] cur_idx;
    logic          cur_any;
    logic          cur_col;
    cmd_kind_e     cur_kind;

    initial begin
        assert (NUM_CLS >= MIN_CLS && NUM_CLS <= MAX_CLS)
            else $error("NUM_CLS out of range");
    end

    clsarb_rr_pick #(.N(NUM_CLS), .IW(IW)) pick_i (
        .req     (cand_valid),
        .ptr     (rr_ptr),
        .win_idx (pick_idx),
        .win_any (pick_any)
    );

    // Select the holder if there is one, otherwise the round-robin winner.
    always_comb begin
        cur_idx  = hold_vld ? hold_idx : pick_idx;
        cur_any  = hold_vld || pick_any;
        cur_kind = cand_col[cur_idx] ? KIND_COL : KIND_ROW;
        cur_col  = (cur_kind == KIND_COL);
    end

    assign cmd_issue = cur_any && cand_valid[cur_idx];

    clsarb_dec #(.N(NUM_CLS), .IW(IW)) dec_i (
        .en  (cur_any),
        .idx (cur_idx),
        .oh  (grant_oh)
    );

    clsarb_hold #(.N(NUM_CLS), .IW(IW)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (cmd_issue),
        .issue_col (cur_col),
        .cur_idx   (cur_idx),
        .hold_vld  (hold_vld),
        .hold_idx  (hold_idx),
        .ptr       (rr_ptr)
    );

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh));  // R1
    AST_ISSUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue == |(grant_oh & cand_valid));  // R1
    AST_ROW_GRANT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue && !(|(grant_oh & cand_col)) |=> grant_oh == $past(grant_oh));  // R3
    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_vld && !(|(grant_oh & cand_valid)) |-> !cmd_issue && grant_oh != '0);  // R5
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_vld && cand_valid == '0 |-> grant_oh == '0 && !cmd_issue);  // R7
endmodule

// File: tb/clsarb_top_tb.sv
`timescale 1ns/1ps
module clsarb_top_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cand_valid = '0;
    logic [N-1:0] cand_col = '0;
    logic [N-1:0] grant_oh;
    logic         cmd_issue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    bit m_hold;
    int m_owner;
    int m_ptr;

    always #2.5 clk = ~clk;

    clsarb_top #(.NUM_CLS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_col(cand_col),
        .grant_oh(grant_oh), .cmd_issue(cmd_issue)
    );

    function automatic int rr_first(input logic [N-1:0] v, input int p);
        for (int k = 0; k < N; k++) begin
            if (v[(p + k) % N]) return (p + k) % N;
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] exp_grant(input logic [N-1:0] v);
        int w;
        w = m_hold ? m_owner : rr_first(v, m_ptr);
        if (w < 0) return '0;
        return N'(1) << w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hold = 1'b0; m_owner = 0; m_ptr = 0;
    endtask

    // Compare outputs against the model, then advance the model by one edge.
    task automatic step_check(input string req);
        logic [N-1:0] eg;
        bit ei;
        int w;
        #1;
        eg = exp_grant(cand_valid);
        ei = |(eg & cand_valid);
        chk(grant_oh == eg, req, "grant", int'(grant_oh), int'(eg));
        chk(cmd_issue == ei, req, "issue", int'(cmd_issue), int'(ei));
        @(posedge clk);
        if (ei) begin
            w = m_hold ? m_owner : rr_first(cand_valid, m_ptr);
            if (cand_col[w]) begin
                m_hold = 1'b0; m_ptr = (w + 1) % N;
            end else begin
                m_hold = 1'b1; m_owner = w;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cand_valid = '0; cand_col = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        int seed;
        int colcnt [N];
        int mx, mn;
        string tag;
        seed = $urandom(32'h5eed_0042);
        @(negedge clk);
        do_reset();

        // R6 and R7: idle after reset
        step_check("R7");
        chk(grant_oh == '0, "R6", "reset grant", int'(grant_oh), 0);

        // R6: pointer starts at 0, so class 1 wins over class 3
        cand_valid = 4'b1010; cand_col = 4'b1010;
        #1; chk(grant_oh == 4'b0010, "R6", "first grant", int'(grant_oh), 2);
        step_check("R6");
        // R4: release moved the pointer to class 2, so class 3 wins now
        #1; chk(grant_oh == 4'b1000, "R4", "after release", int'(grant_oh), 8);
        step_check("R4");
        // R2: wrap past the top, skipping the invalid class 0
        cand_valid = 4'b0110; cand_col = 4'b0000;
        #1; chk(grant_oh == 4'b0010, "R2", "wrap skip", int'(grant_oh), 2);
        step_check("R3");
        // R3: class 1 holds across row commands while class 2 is waiting
        step_check("R3");
        // R5: holder has no candidate, so no other class issues
        cand_valid = 4'b1100;
        #1; chk(grant_oh == 4'b0010 && !cmd_issue, "R5", "stall hold",
                int'({cmd_issue, grant_oh}), 2);
        step_check("R5");
        cand_valid = 4'b0010; cand_col = 4'b0010;
        step_check("R4");
        cand_valid = 4'b1111;
        #1; chk(grant_oh == 4'b0100, "R4", "ptr after class1", int'(grant_oh), 4);

        // Random phase: checks R1, R2, R3, R5, R7 against the model
        for (int c = 0; c < 3000; c++) begin
            cand_valid = N'($urandom);
            cand_col   = N'($urandom);
            if (($urandom % 8) == 0) cand_valid = '0;
            #1;
            chk($onehot0(grant_oh), "R1", "onehot0", int'(grant_oh), 0);
            if (m_hold) tag = cand_valid[m_owner] ? "R3" : "R5";
            else tag = (cand_valid == '0) ? "R7" : "R2";
            step_check(tag);
        end

        // R8: fairness under continuous demand
        do_reset();
        for (int i = 0; i < N; i++) colcnt[i] = 0;
        for (int c = 0; c < 4000; c++) begin
            cand_valid = '1;
            cand_col   = N'($urandom);
            #1;
            for (int i = 0; i < N; i++)
                if (cmd_issue && grant_oh[i] && cand_col[i]) colcnt[i]++;
            step_check("R8");
        end
        mx = colcnt[0]; mn = colcnt[0];
        for (int i = 1; i < N; i++) begin
            if (colcnt[i] > mx) mx = colcnt[i];
            if (colcnt[i] < mn) mn = colcnt[i];
        end
        chk(mx - mn <= 1 && mn > 100, "R8", "column spread", mx - mn, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule